// File: doc/BRIEF.md
# SCSI Controller Register Stub

This block is a byte-wide, memory-mapped register file that takes the place of a SCSI protocol controller in a system that needs the controller's register interface but no real bus activity. A host reaches sixteen byte registers through a simple synchronous read/write port. The register index is taken from address bits 5 down to 2, so the registers sit on 4-byte boundaries and the other address bits are ignored.

A byte written to the command register is stored there, and its low seven bits are decoded as a command. Two commands do something. The chip-reset command puts the register file back to its power-on contents. The select-with-attention command finishes at once with a fixed "no target present" result: it loads the status, interrupt-cause and step registers and raises a level interrupt. That interrupt stays high until a hardware reset or a chip-reset command clears it. Every other command code leaves the rest of the block unchanged.

Top module: `scsi_reg_stub`

## Requirements
- R1: After hardware reset (rst_n low), every register reads 0x00, except index 14, which reads 0x04, and irq is low.
- R2: The register index is address bits [5:2]. Address bits [1:0] and all bits above bit 5 have no effect on which register is accessed.
- R3: A write to index 0, 1, 2 or 8 stores the byte, and a later read of that index returns it.
- R4: Writes to indices 4 to 7 and 9 to 15 are ignored. A read afterwards returns the value held before the write.
- R5: A write to index 3 (the command register) stores the whole byte, and a read of index 3 returns the last command written.
- R6: Command code 0x42 loads index 4 with 0x1A, index 5 with 0x20 and index 6 with 0x04, and drives irq high from the cycle after the write.
- R7: Command code 0x02 clears every register, index 3 included, then sets index 14 to 0x04 and drives irq low from the cycle after the write.
- R8: Only bits [6:0] of a command byte select the command. 0xC2 acts as 0x42, and 0x82 acts as 0x02.
- R9: Command codes 0x00, 0x03, 0x1A and all unlisted codes change no register other than index 3 and leave irq unchanged.
- R10: Once high, irq stays high through reads of any register, including index 5, and through other writes, until a reset clears it.
- R11: rd_data takes the addressed register on the clock edge where rd_en is sampled high. It keeps its value while rd_en is low, and a read has no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address; bits [5:2] select the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
Every result arrives one clock edge after its stimulus. Read data appears on the edge that samples rd_en, and a command's register and irq effects appear on the edge that samples wr_en. The driver changes inputs at falling edges, so a write task can compare irq at the next falling edge. The monitor remembers which edges saw rd_en high and pops the expected byte at the falling edge that follows each one. A separate hold check compares rd_data in idle cycles against the last byte read.

// File: rtl/scsi_reg_stub.sv
module scsi_reg_stub #(
  parameter int ADDR_W   = 8,
  parameter int NREGS    = 16,
  parameter int CMD_IDX  = 3,
  parameter int STAT_IDX = 4,
  parameter int INTR_IDX = 5,
  parameter int STEP_IDX = 6,
  parameter int ID_IDX   = 14,
  parameter logic [7:0] ID_VAL = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic              irq
);
  localparam int IDX_W = $clog2(NREGS);
  localparam logic [6:0] OP_CHIP_RST = 7'h02;
  localparam logic [6:0] OP_SEL_ATN  = 7'h42;

  logic [7:0] regs [NREGS];
  logic [IDX_W-1:0] idx;
  logic [6:0] op;
  logic is_cmd, is_store;

  assign idx = addr[IDX_W+1:2];
  assign op  = wr_data[6:0];
  assign is_cmd = (32'(idx) == CMD_IDX);
  assign is_store = (idx == 4'd0) || (idx == 4'd1) || (idx == 4'd2) || (idx == 4'd8);

  wire unused_addr = ^{addr[ADDR_W-1:IDX_W+2], addr[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= 8'h00;
      regs[ID_IDX] <= ID_VAL;
      irq <= 1'b0;
      rd_data <= 8'h00;
    end else begin
      if (rd_en) rd_data <= regs[idx];
      if (wr_en) begin
        if (is_cmd) begin
          regs[CMD_IDX] <= wr_data;
          case (op)
            OP_CHIP_RST: begin
              for (int i = 0; i < NREGS; i++) regs[i] <= 8'h00;
              regs[ID_IDX] <= ID_VAL;
              irq <= 1'b0;
            end
            OP_SEL_ATN: begin
              regs[STAT_IDX] <= 8'h1A;
              regs[INTR_IDX] <= 8'h20;
              regs[STEP_IDX] <= 8'h04;
              irq <= 1'b1;
            end
            default: ;
          endcase
        end else if (is_store) begin
          regs[idx] <= wr_data;
        end
      end
    end
  end
endmodule

module scsi_reg_stub_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic              rd_en,
  input logic [7:0]        rd_data,
  input logic              irq
);
  logic cmd_wr;
  assign cmd_wr = wr_en && (addr[5:2] == 4'd3);
  wire unused_chk = ^{addr[ADDR_W-1:6], addr[1:0]};

  // R6
  sel_atn_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && wr_data[6:0] == 7'h42 |=> irq);

  // R7
  chip_rst_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && wr_data[6:0] == 7'h02 |=> !irq);

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(cmd_wr && wr_data[6:0] == 7'h02) |=> irq);

  // R9
  other_cmd_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq && !(cmd_wr && wr_data[6:0] == 7'h42) |=> !irq);

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind scsi_reg_stub scsi_reg_stub_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
);

// File: tb/tb_scsi_reg_stub.sv
module tb_scsi_reg_stub;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0, wr_data = 0;
  logic [7:0] rd_data;
  logic irq;
  int checks = 0, errors = 0;

  logic [7:0] model [16];
  logic irq_exp;
  logic [7:0] exp_q [$];
  string tag_q [$];
  logic [7:0] last_rd;
  logic rd_seen = 0;
  bit done = 0;

  always #5 clk = ~clk;

  scsi_reg_stub dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq));

  task automatic model_reset();
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    model[14] = 8'h04;
    irq_exp = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    int i;
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1;
    i = int'(a[5:2]);
    if (i == 3) begin
      model[3] = d;
      if (d[6:0] == 7'h02) model_reset();
      else if (d[6:0] == 7'h42) begin
        model[4] = 8'h1A; model[5] = 8'h20; model[6] = 8'h04; irq_exp = 1;
      end
    end else if (i == 0 || i == 1 || i == 2 || i == 8) model[i] = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1;
    exp_q.push_back(model[a[5:2]]);
    tag_q.push_back(tag);
    last_rd = model[a[5:2]];
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic rd_all(input string tag);
    for (int i = 0; i < 16; i++) rd(8'(i * 4), tag);
  endtask

  task automatic check_irq(input string tag);
    checks++;
    if (irq !== irq_exp) begin
      errors++;
      $display("FAIL %s irq actual %0b expected %0b", tag, irq, irq_exp);
    end
  endtask

  task automatic check_hold(input string tag);
    repeat (3) @(negedge clk);
    checks++;
    if (rd_data !== last_rd) begin
      errors++;
      $display("FAIL %s rd_data hold actual %02h expected %02h", tag, rd_data, last_rd);
    end
  endtask

  always @(posedge clk) rd_seen <= rd_en && rst_n;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s rd_data actual %02h expected %02h", t, rd_data, e);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset contents and irq
    check_irq("R1");
    rd_all("R1");
    // R3 writable registers
    wr(8'h00, 8'hA5); wr(8'h04, 8'h5A); wr(8'h08, 8'h3C); wr(8'h20, 8'h81);
    rd(8'h00, "R3"); rd(8'h04, "R3"); rd(8'h08, "R3"); rd(8'h20, "R3");
    // R2 address aliasing
    wr(8'h05, 8'h11); rd(8'h47, "R2");
    wr(8'hE1, 8'h22); rd(8'h00, "R2"); rd(8'hC3, "R2");
    // R4 ignored writes
    for (int i = 4; i < 16; i++) if (i != 8) wr(8'(i * 4), 8'hFF);
    rd_all("R4");
    // R5 / R9 inert commands
    wr(8'h0C, 8'h00); rd(8'h0C, "R5");
    wr(8'h0C, 8'h03); wr(8'h0C, 8'h1A); wr(8'h0C, 8'h55);
    check_irq("R9");
    rd_all("R9");
    // R6 select with attention
    wr(8'h0C, 8'h42);
    check_irq("R6");
    rd(8'h10, "R6"); rd(8'h14, "R6"); rd(8'h18, "R6"); rd(8'h0C, "R5");
    // R10 sticky irq
    rd(8'h14, "R10"); rd(8'h14, "R10"); wr(8'h0C, 8'h03); wr(8'h00, 8'h77);
    check_irq("R10");
    // R11 hold and no side effect
    rd(8'h00, "R11");
    check_hold("R11");
    check_irq("R11");
    // R7 chip reset command
    wr(8'h0C, 8'h02);
    check_irq("R7");
    rd_all("R7");
    // R8 bit 7 ignored
    wr(8'h0C, 8'hC2);
    check_irq("R8");
    rd(8'h10, "R8"); rd(8'h0C, "R8");
    wr(8'h00, 8'h99);
    wr(8'h0C, 8'h82);
    check_irq("R8");
    rd_all("R8");
    // R1 hardware reset while irq high
    wr(8'h0C, 8'h42); wr(8'h20, 8'h66);
    @(negedge clk); rst_n = 0;
    model_reset();
    @(negedge clk); @(negedge clk); rst_n = 1;
    check_irq("R1");
    rd_all("R1");
    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule